// File: doc/BRIEF.md
# Cascadable Bidirectional Row Scan Register

This block walks a single active token through a chain of row stages, one stage per line period, and turns each stage into a 2-bit drive-level code for a row output of a passive-matrix display. The code depends on the token and on the frame alternation input. External analog switches use the code to choose a bias voltage. The scan order can run upward or downward. A phase input picks whether the token moves on the rising or on the falling edge of the line clock. That clock is sampled by the system clock `clk`, so an advance is a one-cycle strobe in the `clk` domain.

Several devices can be chained to drive more rows. In master mode, a frame-start pulse injects the token. In slave mode, the token enters from the upstream device's carry pin. Each of the two cascade pins is shown as its own output-enable, output-data and input-data signals. The scan direction decides which pin receives the carry and which pin drives it.

A small controller tracks the scan with three named states. `ST_IDLE` means no token is present. `ST_SCAN` means the token sits in any stage except the final one. `ST_TAIL` means the token sits in the final stage for the current direction. The transitions happen only on an advance. A load (frame start in master mode, carry-in in slave mode) moves any state to `ST_SCAN`. `ST_SCAN` moves to `ST_TAIL` when the token steps into the final stage. `ST_TAIL` moves to `ST_IDLE` when the token steps out and no load arrives. The carry output is high while the controller is in `ST_TAIL`. The scan direction and the mode are fixed from reset. A slave receives a carry only when it holds no token, or while its token is in the final stage.

Top module: `row_scan_reg`

## Requirements
- R1: After reset, no row holds the token and the carry output is 0. Every row then shows the inactive code for the current alternation value: 2'b01 when alternation is 0, 2'b10 when it is 1.
- R2: With `scan_dir`=1, successive advances move the token from row 0 up to row 63, one row per advance, and at most one row holds it.
- R3: With `scan_dir`=0, successive advances move the token from row 63 down to row 0, one row per advance.
- R4: The code for row i sits at `row_level[2i+1:2i]`. It is set by the pair (alternation, token) as follows: (0,0) gives 2'b01, (0,1) gives 2'b11, (1,0) gives 2'b10, and (1,1) gives 2'b00. The codes stand for the levels V1, V5, V4 and V0.
- R5: With `phase_sel`=1, only a rising edge of `line_clk` advances the scan; with `phase_sel`=0, only a falling edge does. The row outputs change in the `clk` cycle in which the selected edge is first sampled.
- R6: In master mode both cascade pins are output-enabled. The carry is driven on pin B when `scan_dir`=1 and on pin A when `scan_dir`=0, and the other pin drives 0.
- R7: In slave mode with `scan_dir`=1, pin A is the input (oe 0) and pin B drives the carry. With `scan_dir`=0, pin B is the input and pin A drives the carry. A disabled pin's output data is 0, and the input data of the output pin is ignored.
- R8: The carry is 1 exactly while the final row for the current direction holds the token (row 63 upward, row 0 downward).
- R9: In master mode, a frame start sampled on an advance places the token in the first row for the current direction and clears every other row, even in the middle of a scan.
- R10: In slave mode, a carry-in sampled on an advance places the token in the first row for the current direction, and the frame-start input has no effect.
- R11: Between advances, the row codes and the carry do not change except through the alternation input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk | input | 1 | Line clock, sampled by clk |
| phase_sel | input | 1 | 1: advance on rising line_clk edge, 0: on falling edge |
| scan_dir | input | 1 | 1: row 0 towards row 63, 0: row 63 towards row 0 |
| is_master | input | 1 | 1: master mode, 0: slave mode |
| frame_start | input | 1 | Token injection at the master |
| alt_phase | input | 1 | Frame alternation polarity |
| casc_a_in | input | 1 | Cascade pin A input data |
| casc_b_in | input | 1 | Cascade pin B input data |
| casc_a_oe | output | 1 | Cascade pin A output enable |
| casc_a_out | output | 1 | Cascade pin A output data |
| casc_b_oe | output | 1 | Cascade pin B output enable |
| casc_b_out | output | 1 | Cascade pin B output data |
| row_level | output | 128 | Two-bit level code per row |

## Verification
Two functions can land on the same advance. In a master, a frame restart can arrive while the token is still in the final row, so the carry drops and the first row loads in the same cycle. In a slave, an upstream carry can arrive on the same advance that moves the token out of the final row. The random stimulus deliberately raises the frame start (master) or the carry-in (slave) while the reference token sits in the final stage. Next to these collisions it also injects restarts in the middle of a frame and loads into an empty register. After each advance, the bench compares every row code, the carry and all four pin signals against a bench-side token vector. That vector is shifted according to the direction rules.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_TAIL = 2'd2
    } scan_state_t;

    localparam logic [1:0] LVL_V0 = 2'b00;
    localparam logic [1:0] LVL_V1 = 2'b01;
    localparam logic [1:0] LVL_V4 = 2'b10;
    localparam logic [1:0] LVL_V5 = 2'b11;
endpackage

// File: rtl/rsr_edge_pick.sv
module rsr_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic phase_sel,
    output logic advance
);
    logic lc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lc_q <= 1'b0;
        else        lc_q <= line_clk;
    end

    always_comb begin
        if (phase_sel) advance = line_clk & ~lc_q;
        else           advance = ~line_clk & lc_q;
    end
endmodule

// File: rtl/rsr_token_chain.sv
module rsr_token_chain #(
    parameter int N_ROWS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              scan_dir,
    input  logic              load_first,
    input  logic              feed_in,
    output logic [N_ROWS-1:0] tok,
    output logic              tail_hit
);
    logic [N_ROWS-1:0] shifted;
    logic [N_ROWS-1:0] first_mask;

    for (genvar i = 0; i < N_ROWS; i++) begin : g_stage
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lo_edge
            assign from_low = feed_in;
        end else begin : g_lo_mid
            assign from_low = tok[i-1];
        end
        if (i == N_ROWS - 1) begin : g_hi_edge
            assign from_high = feed_in;
        end else begin : g_hi_mid
            assign from_high = tok[i+1];
        end
        assign shifted[i] = scan_dir ? from_low : from_high;
    end

    always_comb begin
        first_mask = '0;
        if (scan_dir) first_mask[0]        = 1'b1;
        else          first_mask[N_ROWS-1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          tok <= '0;
        else if (advance)    tok <= load_first ? first_mask : shifted;
    end

    assign tail_hit = scan_dir ? tok[N_ROWS-1] : tok[0];

    // R11: the chain holds still between advances
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tok));
endmodule

// File: rtl/rsr_level_enc.sv
module rsr_level_enc #(
    parameter int N_ROWS = 64
) (
    input  logic                alt_phase,
    input  logic [N_ROWS-1:0]   tok,
    output logic [2*N_ROWS-1:0] row_level
);
    import rsr_pkg::*;

    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        always_comb begin
            unique case ({alt_phase, tok[i]})
                2'b00:   row_level[2*i +: 2] = LVL_V1;
                2'b01:   row_level[2*i +: 2] = LVL_V5;
                2'b10:   row_level[2*i +: 2] = LVL_V4;
                default: row_level[2*i +: 2] = LVL_V0;
            endcase
        end
    end
endmodule

// File: rtl/rsr_pin_map.sv
module rsr_pin_map (
    input  logic is_master,
    input  logic scan_dir,
    input  logic carry,
    input  logic pin_a_in,
    input  logic pin_b_in,
    output logic pin_a_oe,
    output logic pin_a_out,
    output logic pin_b_oe,
    output logic pin_b_out,
    output logic carry_in
);
    always_comb begin
        pin_a_out = scan_dir ? 1'b0 : carry;
        pin_b_out = scan_dir ? carry : 1'b0;
        pin_a_oe  = is_master | ~scan_dir;
        pin_b_oe  = is_master | scan_dir;
        carry_in  = is_master ? 1'b0 : (scan_dir ? pin_a_in : pin_b_in);
    end
endmodule

// File: rtl/row_scan_reg.sv
module row_scan_reg #(
    parameter int N_ROWS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_clk,
    input  logic                phase_sel,
    input  logic                scan_dir,
    input  logic                is_master,
    input  logic                frame_start,
    input  logic                alt_phase,
    input  logic                casc_a_in,
    input  logic                casc_b_in,
    output logic                casc_a_oe,
    output logic                casc_a_out,
    output logic                casc_b_oe,
    output logic                casc_b_out,
    output logic [2*N_ROWS-1:0] row_level
);
    import rsr_pkg::*;

    localparam int PW = $clog2(N_ROWS);

    logic              advance;
    logic              carry_in;
    logic              carry_out;
    logic              load_any;
    logic              tail_hit;
    logic [N_ROWS-1:0] tok;
    scan_state_t       state, state_n;
    logic [PW-1:0]     pos, pos_n;

    rsr_edge_pick u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .phase_sel (phase_sel),
        .advance   (advance)
    );

    rsr_pin_map u_pins (
        .is_master (is_master),
        .scan_dir  (scan_dir),
        .carry     (carry_out),
        .pin_a_in  (casc_a_in),
        .pin_b_in  (casc_b_in),
        .pin_a_oe  (casc_a_oe),
        .pin_a_out (casc_a_out),
        .pin_b_oe  (casc_b_oe),
        .pin_b_out (casc_b_out),
        .carry_in  (carry_in)
    );

    assign load_any = is_master ? frame_start : carry_in;

    rsr_token_chain #(.N_ROWS(N_ROWS)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .scan_dir   (scan_dir),
        .load_first (is_master & frame_start),
        .feed_in    (carry_in),
        .tok        (tok),
        .tail_hit   (tail_hit)
    );

    rsr_level_enc #(.N_ROWS(N_ROWS)) u_enc (
        .alt_phase (alt_phase),
        .tok       (tok),
        .row_level (row_level)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        pos_n     = pos;
        carry_out = (state == ST_TAIL);
        if (advance) begin
            if (load_any) begin
                state_n = ST_SCAN;
                pos_n   = '0;
            end else begin
                unique case (state)
                    ST_IDLE: state_n = ST_IDLE;
                    ST_SCAN: begin
                        pos_n = pos + 1'b1;
                        if (pos == PW'(N_ROWS - 2)) state_n = ST_TAIL;
                    end
                    ST_TAIL: state_n = ST_IDLE;
                    default: state_n = ST_IDLE;
                endcase
            end
        end
    end

    // R8: controller tail state agrees with the chain's final stage
    assert_tail_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == tail_hit);

    // R2: a master never carries more than one token
    assert_single_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> $onehot0(tok));

    // R6: a master enables both cascade pins
    assert_master_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> (casc_a_oe && casc_b_oe));

    // R9: a frame start on an advance leaves exactly one token, not in the tail
    assert_frame_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && is_master && frame_start) |=> ($countones(tok) == 1 && !carry_out));

    // R7: a slave enables exactly one cascade pin
    assert_slave_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (casc_a_oe != casc_b_oe));
endmodule

// File: tb/row_scan_reg_test.sv
module row_scan_reg_test;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 1'b0, phase_sel = 1'b1, scan_dir = 1'b1, is_master = 1'b1;
    logic frame_start = 1'b0, alt_phase = 1'b0, casc_a_in = 1'b0, casc_b_in = 1'b0;
    logic casc_a_oe, casc_a_out, casc_b_oe, casc_b_out;
    logic [2*N-1:0] row_level;

    int n_checks = 0;
    int n_fail = 0;
    logic [N-1:0] exp_tok;

    always #4 clk = ~clk;

    row_scan_reg #(.N_ROWS(N)) uut (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .phase_sel(phase_sel),
        .scan_dir(scan_dir), .is_master(is_master), .frame_start(frame_start),
        .alt_phase(alt_phase), .casc_a_in(casc_a_in), .casc_b_in(casc_b_in),
        .casc_a_oe(casc_a_oe), .casc_a_out(casc_a_out), .casc_b_oe(casc_b_oe),
        .casc_b_out(casc_b_out), .row_level(row_level)
    );

    function automatic logic [2*N-1:0] exp_levels(logic alt, logic [N-1:0] t);
        logic [2*N-1:0] r;
        for (int i = 0; i < N; i++) begin
            case ({alt, t[i]})
                2'b00:   r[2*i +: 2] = 2'b01;
                2'b01:   r[2*i +: 2] = 2'b11;
                2'b10:   r[2*i +: 2] = 2'b10;
                default: r[2*i +: 2] = 2'b00;
            endcase
        end
        return r;
    endfunction

    function automatic logic [N-1:0] first_row(logic d);
        return d ? N'(1) : (N'(1) << (N - 1));
    endfunction

    function automatic logic [N-1:0] step(logic d, logic [N-1:0] t, logic feed);
        if (d) return {t[N-2:0], feed};
        return {feed, t[N-1:1]};
    endfunction

    function automatic logic tail_of(logic d, logic [N-1:0] t);
        return d ? t[N-1] : t[0];
    endfunction

    task automatic chk(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        logic c;
        c = tail_of(scan_dir, exp_tok);
        chk({ctx, scan_dir ? " R2/R4 levels" : " R3/R4 levels"}, row_level,
            exp_levels(alt_phase, exp_tok));
        chk({ctx, " R8 carry"}, (2*N)'(is_master ? (scan_dir ? casc_b_out : casc_a_out)
                                           : (scan_dir ? casc_b_out : casc_a_out)), (2*N)'(c));
        if (is_master)
            chk({ctx, " R6 pins"}, (2*N)'({casc_a_oe, casc_a_out, casc_b_oe, casc_b_out}),
                (2*N)'({1'b1, scan_dir ? 1'b0 : c, 1'b1, scan_dir ? c : 1'b0}));
        else
            chk({ctx, " R7 pins"}, (2*N)'({casc_a_oe, casc_a_out, casc_b_oe, casc_b_out}),
                (2*N)'({~scan_dir, scan_dir ? 1'b0 : c, scan_dir, scan_dir ? c : 1'b0}));
    endtask

    task automatic do_reset(logic m, logic d, logic p);
        @(negedge clk);
        rst_n = 1'b0; is_master = m; scan_dir = d; phase_sel = p;
        line_clk = 1'b0; frame_start = 1'b0; casc_a_in = 1'b0; casc_b_in = 1'b0;
        alt_phase = 1'($urandom_range(0, 1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_tok = '0;
        @(negedge clk);
        check_all("R1 reset");
    endtask

    // one half line: toggle line_clk with stimulus, then idle cycles
    task automatic half_line(int line_no);
        logic new_lc, sel, fs, cin, garbage;
        new_lc = ~line_clk;
        sel = phase_sel ? new_lc : ~new_lc;
        fs = 1'b0; cin = 1'b0;
        garbage = 1'($urandom_range(0, 1));
        if (is_master) begin
            if (exp_tok == '0 || tail_of(scan_dir, exp_tok)) fs = ($urandom_range(0, 1) == 0);
            else if (line_no > 140) fs = ($urandom_range(0, 19) == 0);
        end else begin
            if (exp_tok == '0 || tail_of(scan_dir, exp_tok)) cin = ($urandom_range(0, 2) == 0);
            fs = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        line_clk = new_lc;
        frame_start = fs;
        if (scan_dir) begin casc_a_in = is_master ? garbage : cin; casc_b_in = garbage; end
        else          begin casc_b_in = is_master ? garbage : cin; casc_a_in = garbage; end
        @(posedge clk);
        if (sel) begin
            if (is_master && fs) exp_tok = first_row(scan_dir);
            else                 exp_tok = step(scan_dir, exp_tok, is_master ? 1'b0 : cin);
        end
        @(negedge clk);
        if (!sel)                     check_all("R5 unselected edge");
        else if (is_master && fs)     check_all("R9 frame load");
        else if (!is_master && fs)    check_all("R10 slave ignores frame start");
        else if (!is_master && cin)   check_all("R10 carry-in load");
        else                          check_all("advance");
        frame_start = 1'b0; casc_a_in = 1'b0; casc_b_in = 1'b0;
        repeat ($urandom_range(1, 2)) begin
            if ($urandom_range(0, 7) == 0) alt_phase = ~alt_phase;
            @(negedge clk);
            check_all("R11 idle hold");
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int seg = 0; seg < 8; seg++) begin
            do_reset(~seg[2], seg[0], seg[1]);
            if (seg[2] == 1'b0) begin
                // directed: frame start on the first selected edge, then a full clean frame
                for (int h = 0; h < 2 * (N + 4); h++) begin
                    logic nl, sel;
                    nl = ~line_clk;
                    sel = phase_sel ? nl : ~nl;
                    @(negedge clk);
                    line_clk = nl;
                    frame_start = (h < 2) && sel;
                    @(posedge clk);
                    if (sel) exp_tok = frame_start ? first_row(scan_dir)
                                                   : step(scan_dir, exp_tok, 1'b0);
                    @(negedge clk);
                    check_all(scan_dir ? "R2 directed scan" : "R3 directed scan");
                    frame_start = 1'b0;
                end
            end
            for (int l = 0; l < 300; l++) half_line(l);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule